// File: doc/BRIEF.md
# Interrupt Priority Level Recognizer

This block watches an encoded priority level arriving on active-low pins and decides when a processor core should take an interrupt. It compares the level with a three-bit mask taken from the status register. Levels one through six raise a request only when they exceed the mask. The top level is non-maskable and is taken once for each entry into that level. A level counts only after it has been sampled with the same value on two consecutive clocks, so short glitches and slow transitions on the pins are filtered out.

When the core begins an interrupt-acknowledge bus cycle, it pulses `ack_start`. The block then captures the level being serviced and holds it until `ack_end`, even if the pins change in the meantime. During that time it presents the acknowledge address pattern: the serviced level sits in address bits 3:1, and every other bit is driven high.

A reduced-pin mode serves packages with fewer pins. In that mode one wire feeds both bit 0 and bit 2 of the level, so only levels 0, 2, 5 and 7 can be expressed.

Top module: `irq_level_recognizer`

## Requirements
- R1: The pins are active low. Pin vector bit i low means level bit i is 1, so all pins high is level 0. Level 0 never raises `irq_pending`. After reset, `irq_pending` is 0, `pending_level` is 0 and `ack_addr` is 20'hFFFF1.
- R2: A level from 1 to 6 is reported on `pending_level` with `irq_pending` high only while it is strictly greater than `level_mask`. A level equal to or below the mask is reported as 0.
- R3: Level 7 is recognized whatever the mask holds, including a mask of 7. It is recognized once per entry into level 7. It becomes recognizable again only after a different level has been stably sampled.
- R4: A new input level is reported three rising edges after it is applied, because it must be sampled equal on two consecutive clocks. A level that changes on every clock is never reported, and a single-cycle level 7 is never reported.
- R5: The pins are watched continuously. A masked level that is later replaced by a level above the mask is reported once the new level is stable.
- R6: When `reduced_pins` is 1, pin 0 drives level bits 0 and 2, pin 1 drives level bit 1, and pin 2 is ignored. The only reachable levels are 0, 2, 5 and 7.
- R7: `ack_addr` carries the shown level in bits 3:1, with bit 0 and all bits from 4 upward set to 1. The shown level is the serviced level during an acknowledge and the current pending level otherwise.
- R8: An `ack_start` pulse outside an acknowledge captures the pending level. `pending_level` and `ack_addr` then hold the captured level until an `ack_end` pulse, regardless of pin changes. `irq_pending` keeps following the live request during this time.
- R9: Servicing level 7 clears its edge-captured request, so a level 7 that is still held afterwards leaves `irq_pending` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_n | input | 3 | Active-low encoded priority level pins |
| level_mask | input | 3 | Current interrupt mask from the status register |
| reduced_pins | input | 1 | 1 selects the shared-wire reduced-pin mode |
| ack_start | input | 1 | Pulse that starts an interrupt-acknowledge cycle |
| ack_end | input | 1 | Pulse that ends the acknowledge cycle |
| irq_pending | output | 1 | A recognized interrupt request is present |
| pending_level | output | 3 | Pending level, or the serviced level during acknowledge |
| ack_addr | output | 20 | Acknowledge address pattern |

## Verification
Vectors sweep every level against masks just below, equal to and above it. This separates a strict comparison from a greater-or-equal one. The reduced-pin vectors drive pin 2 low on its own and together with pin 1, which shows whether pin 2 is truly ignored and whether bits 0 and 2 follow pin 0. Directed patterns cover several timing and sequencing cases. A one-edge-early sample and an alternating input tell a two-sample filter apart from a one-sample filter. A masked-then-raised sequence shows that the pins are watched continuously. Holding level 7 across an acknowledge and then dropping it and raising it again shows the difference between edge recognition and level recognition. Changing the pins during an acknowledge shows whether the serviced level is latched or live.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        lvl_t smp;
        lvl_t prev;
        lvl_t acc;
    } filt_state_t;

    typedef struct packed {
        logic arm;
        logic nmi;
    } edge_state_t;

    typedef struct packed {
        lvl_t req_lvl;
        logic in_ack;
        lvl_t svc;
    } ack_state_t;
endpackage

// File: rtl/irq_pin_decode.sv
module irq_pin_decode
    import irq_rec_pkg::*;
(
    input  logic [LVL_W-1:0] pins_n,
    input  logic             reduced,
    output logic [LVL_W-1:0] lvl
);
    logic [LVL_W-1:0] raw;

    always_comb begin
        raw = ~pins_n;
        if (reduced) begin
            lvl    = '0;
            lvl[0] = raw[0];
            lvl[1] = raw[1];
            lvl[2] = raw[0];
        end else begin
            lvl = raw;
        end
    end

    always_comb begin
        if (reduced) a_r6_shared_wire: assert (lvl[0] == lvl[2] && lvl[0] == ~pins_n[0]);
    end
endmodule

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import irq_rec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_in,
    output logic             stable,
    output logic [LVL_W-1:0] smp_lvl,
    output logic [LVL_W-1:0] acc_next
);
    filt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.smp  = lvl_in;
        st_d.prev = st_q.smp;
        stable    = (st_q.smp == st_q.prev);
        if (stable) st_d.acc = st_q.smp;
        smp_lvl   = st_q.smp;
        acc_next  = st_d.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r4_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc != $past(st_q.acc)) |-> $past(st_q.smp == st_q.prev));
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge
    import irq_rec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stable,
    input  logic [LVL_W-1:0] smp_lvl,
    input  logic             clear,
    output logic             nmi_next
);
    localparam lvl_t LVL_TOP = '1;
    edge_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d = st_q;
        fire = stable && (smp_lvl == LVL_TOP) && st_q.arm;
        if (fire) st_d.arm = 1'b0;
        else if (stable && smp_lvl != LVL_TOP) st_d.arm = 1'b1;
        if (fire)       st_d.nmi = 1'b1;
        else if (clear) st_d.nmi = 1'b0;
        nmi_next = st_d.nmi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.arm <= 1'b1;
            st_q.nmi <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r3_edge_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nmi) |-> $past(st_q.arm));
    a_r9_clear_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !fire) |=> !st_q.nmi);
endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer
    import irq_rec_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  irq_pins_n,
    input  logic [LVL_W-1:0]  level_mask,
    input  logic              reduced_pins,
    input  logic              ack_start,
    input  logic              ack_end,
    output logic              irq_pending,
    output logic [LVL_W-1:0]  pending_level,
    output logic [ADDR_W-1:0] ack_addr
);
    localparam lvl_t LVL_TOP = '1;
    localparam int   HI_W    = ADDR_W - LVL_W - 1;

    lvl_t       dec_lvl, smp_lvl, acc_next;
    logic       stable, nmi_next, nmi_clear, maskable;
    ack_state_t st_d, st_q;
    lvl_t       shown;

    irq_pin_decode u_dec (
        .pins_n  (irq_pins_n),
        .reduced (reduced_pins),
        .lvl     (dec_lvl)
    );

    irq_level_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (dec_lvl),
        .stable   (stable),
        .smp_lvl  (smp_lvl),
        .acc_next (acc_next)
    );

    assign nmi_clear = ack_start && !st_q.in_ack && (st_q.req_lvl == LVL_TOP);

    irq_nmi_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stable   (stable),
        .smp_lvl  (smp_lvl),
        .clear    (nmi_clear),
        .nmi_next (nmi_next)
    );

    always_comb begin
        st_d     = st_q;
        maskable = (acc_next != '0) && (acc_next != LVL_TOP) && (acc_next > level_mask);
        if (nmi_next)      st_d.req_lvl = LVL_TOP;
        else if (maskable) st_d.req_lvl = acc_next;
        else               st_d.req_lvl = '0;
        if (st_q.in_ack) begin
            if (ack_end) st_d.in_ack = 1'b0;
        end else if (ack_start) begin
            st_d.in_ack = 1'b1;
            st_d.svc    = st_q.req_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shown         = st_q.in_ack ? st_q.svc : st_q.req_lvl;
    assign irq_pending   = (st_q.req_lvl != '0);
    assign pending_level = shown;
    assign ack_addr      = {{HI_W{1'b1}}, shown, 1'b1};

    a_r2_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req_lvl != '0 && st_q.req_lvl != LVL_TOP) |-> (st_q.req_lvl > $past(level_mask)));
    a_r7_ack_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.in_ack) |-> (ack_addr[LVL_W:1] == $past(st_q.req_lvl) && ack_addr[0]));
    a_r8_hold_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_ack && $past(st_q.in_ack)) |-> $stable(pending_level));
endmodule

// File: tb/irq_level_recognizer_tb.sv
module irq_level_recognizer_tb;
    localparam int ADDR_W = 20;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        pins_n = 3'b111;
    logic [2:0]        mask = 3'd0;
    logic              red = 1'b0;
    logic              ack_start = 1'b0;
    logic              ack_end = 1'b0;
    logic              irq_pending;
    logic [2:0]        pending_level;
    logic [ADDR_W-1:0] ack_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_level_recognizer #(.ADDR_W(ADDR_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_pins_n    (pins_n),
        .level_mask    (mask),
        .reduced_pins  (red),
        .ack_start     (ack_start),
        .ack_end       (ack_end),
        .irq_pending   (irq_pending),
        .pending_level (pending_level),
        .ack_addr      (ack_addr)
    );

    // {reduced, pins_n, mask, expected level}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 3'b111, 3'd0, 3'd0},
        {1'b0, 3'b110, 3'd0, 3'd1},
        {1'b0, 3'b101, 3'd1, 3'd2},
        {1'b0, 3'b100, 3'd3, 3'd0},
        {1'b0, 3'b011, 3'd3, 3'd4},
        {1'b0, 3'b010, 3'd5, 3'd0},
        {1'b0, 3'b001, 3'd5, 3'd6},
        {1'b0, 3'b001, 3'd6, 3'd0},
        {1'b1, 3'b110, 3'd0, 3'd5},
        {1'b1, 3'b101, 3'd1, 3'd2},
        {1'b1, 3'b001, 3'd0, 3'd2},
        {1'b1, 3'b011, 3'd0, 3'd0},
        {1'b1, 3'b110, 3'd5, 3'd0}
    };

    function automatic logic [ADDR_W-1:0] addr_of(input logic [2:0] l);
        return {{(ADDR_W-4){1'b1}}, l, 1'b1};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_level(input string tag, input logic [2:0] l);
        check({tag, " pending"}, 32'(irq_pending), 32'(l != 3'd0));
        check({tag, " level"}, 32'(pending_level), 32'(l));
        check({tag, " addr"}, 32'(ack_addr), 32'(addr_of(l)));
    endtask

    task automatic pulse_start();
        ack_start = 1'b1; @(negedge clk); ack_start = 1'b0;
    endtask

    task automatic pulse_end();
        ack_end = 1'b1; @(negedge clk); ack_end = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        edges(2);
        check_level("R1 reset", 3'd0);
        rst_n = 1'b1;
        edges(3);
        check_level("R1 idle pins", 3'd0);

        // R2, R6, R7: table walk
        for (int i = 0; i < NVEC; i++) begin
            red    = VEC[i][9];
            pins_n = VEC[i][8:6];
            mask   = VEC[i][5:3];
            edges(3);
            check_level($sformatf("R2/R6/R7 vec%0d", i), VEC[i][2:0]);
        end
        red = 1'b0; pins_n = 3'b111; mask = 3'd0;
        edges(3);

        // R4: latency of exactly three edges
        pins_n = 3'b011;
        edges(2);
        check("R4 not yet at edge 2", 32'(irq_pending), 32'd0);
        edges(1);
        check("R4 level 4 at edge 3", 32'(pending_level), 32'd4);
        pins_n = 3'b111;
        edges(3);

        // R4: alternating input never recognized
        for (int k = 0; k < 10; k++) begin
            pins_n = (k % 2 == 0) ? 3'b100 : 3'b010;
            edges(1);
            check("R4 toggling", 32'(irq_pending), 32'd0);
        end
        pins_n = 3'b111;
        edges(3);

        // R4: single-cycle level 7 glitch ignored
        pins_n = 3'b000;
        edges(1);
        pins_n = 3'b111;
        edges(4);
        check("R4 glitch level 7", 32'(irq_pending), 32'd0);

        // R5: masked level replaced by higher one
        mask = 3'd4; pins_n = 3'b100;
        edges(3);
        check("R5 level 3 masked", 32'(irq_pending), 32'd0);
        pins_n = 3'b010;
        edges(3);
        check_level("R5 level 5 seen", 3'd5);

        // R3, R9: level 7 with mask 7, edge behaviour
        mask = 3'd7; pins_n = 3'b000;
        edges(3);
        check_level("R3 level 7 over mask 7", 3'd7);
        pulse_start();
        check("R7 addr during ack of 7", 32'(ack_addr), 32'(addr_of(3'd7)));
        edges(1);
        check("R9 cleared while 7 held", 32'(irq_pending), 32'd0);
        check("R8 svc level 7 held", 32'(pending_level), 32'd7);
        pulse_end();
        edges(5);
        check_level("R3 no retrigger", 3'd0);
        pins_n = 3'b100;
        edges(3);
        pins_n = 3'b000;
        edges(3);
        check_level("R3 rearmed", 3'd7);
        pulse_start();
        pulse_end();
        pins_n = 3'b111; mask = 3'd0;
        edges(3);

        // R8: serviced level latched while pins change
        pins_n = 3'b011;
        edges(3);
        pulse_start();
        pins_n = 3'b001;
        edges(4);
        check("R8 level latched", 32'(pending_level), 32'd4);
        check("R8 addr latched", 32'(ack_addr), 32'(addr_of(3'd4)));
        check("R8 pending live", 32'(irq_pending), 32'd1);
        pulse_end();
        check("R8 after end", 32'(pending_level), 32'd6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule